// File: doc/BRIEF.md
# PRBS9 Error Checker with Self-Alignment

The block takes in a serial stream, one bit per cycle in which `in_valid_i` is high. The stream is expected to carry the PRBS9 pattern x^9 + x^5 + 1. No alignment signal from the sender is needed. While hunting for alignment, the checker loads every received bit into its own 9-bit register. In parallel, it predicts each incoming bit from two taps of that register. Once enough predictions in a row are correct, the register stops listening to the line and runs as a free generator. From then on, every received bit is compared with the generator's output, and the checker accumulates a counted-bit total and a counted-error total. Software derives the error ratio from these two totals.

A watchdog on error density covers the locked phase. It counts errors over consecutive 128-bit periods. If a period shows too many errors, lock is dropped and the hunt starts again. A missed frame or a slipped stream therefore cannot inflate the totals indefinitely.

The control has two states:
- **SEARCH** is the reset state, in which the checker hunts for alignment. It leaves SEARCH on the transition *run complete*, which is the 18th consecutive correct prediction.
- **LOCKED** is the error-counting state. It leaves LOCKED on the transition *window overflow*, which is the 19th error inside one 128-bit period. That transition returns the checker to SEARCH.

Top module: `prbs9_checker`

## Requirements
- R1: After reset, `locked_o` is 0, `err_flag_o` is 0, both totals are 0, and the internal 9-bit register holds the value 1. As a result, a stream produced by a generator that was also seeded with 1 matches from its first bit.
- R2: In SEARCH, the predicted bit is register bit 8 XOR register bit 4, and a mismatch is the received bit XOR that prediction. The received bit, not the prediction, shifts into register bit 0. `err_flag_o` shows the mismatch of each valid bit in the cycle after the strobe.
- R3: A mismatch in SEARCH clears the run of correct predictions. `locked_o` rises in the cycle after the valid bit that completes a run of 18 correct predictions, and not earlier.
- R4: One corrupted bit in SEARCH raises `err_flag_o` three times: on the bit itself, on the bit 5 positions later, and on the bit 9 positions later.
- R5: Bits received in SEARCH, whether during the first hunt or after a lost lock, change neither total.
- R6: In LOCKED, the register shifts in its own prediction, so corrupted input cannot disturb it. Each valid bit adds 1 to `bit_total_o`, and each mismatch adds 1 to `err_total_o`. `err_flag_o` equals the injected corruption, bit for bit.
- R7: The 128-bit periods start at the *run complete* transition. In LOCKED, a period with up to 18 errors keeps lock. The bit that brings a period to 19 errors is still counted, and `locked_o` falls in the following cycle.
- R8: Both totals are CNT_W bits wide and saturate at all ones.
- R9: `clr_i` zeroes both totals on the next edge. It takes priority over a bit counted in the same cycle, and it leaves lock and the register untouched.
- R10: A cycle with `in_valid_i` low changes no state and no output, whatever `in_bit_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Synchronous clear of both totals |
| in_valid_i | input | 1 | Strobe: `in_bit_i` carries a received bit |
| in_bit_i | input | 1 | Received serial bit |
| locked_o | output | 1 | High in LOCKED |
| err_flag_o | output | 1 | Mismatch of the previous valid bit |
| bit_total_o | output | CNT_W | Bits counted while locked |
| err_total_o | output | CNT_W | Errors counted while locked |

## Verification
The assertions assume that reset is held from time zero until the first clock edge, and that `in_valid_i`, `in_bit_i` and `clr_i` are never unknown once reset is released. They make no assumption about how often the strobe fires. The stimulus changes every input only at the falling clock edge. It holds reset high from the start of the run, and it drives every input to a defined level before reset is released. It exercises strobe gaps and a clear that coincides with a counted bit explicitly, not by chance.

// File: rtl/prbs9_pkg.sv
package prbs9_pkg;

    localparam int unsigned PRBS_LEN   = 9;
    localparam int unsigned PRBS_TAP_A = 8;
    localparam int unsigned PRBS_TAP_B = 4;

    typedef enum logic [0:0] {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } chk_state_e;

endpackage

// File: rtl/prbs9_lfsr.sv
module prbs9_lfsr #(
    parameter int unsigned LEN   = 9,
    parameter int unsigned TAP_A = 8,
    parameter int unsigned TAP_B = 4,
    parameter logic [LEN-1:0] SEED = LEN'(1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    input  logic follow_i,
    input  logic rx_bit_i,
    output logic pred_o
);

    logic [LEN-1:0] state_q;
    logic           shift_in;

    assign pred_o   = state_q[TAP_A] ^ state_q[TAP_B];
    assign shift_in = follow_i ? rx_bit_i : pred_o;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= {state_q[LEN-2:0], shift_in};
        end
    end

    AST_FREE_RUN_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !follow_i && state_q != '0) |=> (state_q != '0)); // R6

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!step_i) |=> $stable(state_q)); // R10

endmodule

// File: rtl/prbs9_sync_fsm.sv
module prbs9_sync_fsm
    import prbs9_pkg::*;
#(
    parameter int unsigned LOCK_RUN = 18
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    input  logic mis_i,
    input  logic fail_i,
    output logic locked_o,
    output logic lock_evt_o
);

    localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

    chk_state_e       state_q, state_d;
    logic [RUN_W-1:0] run_q;

    always_comb begin
        state_d    = state_q;
        lock_evt_o = 1'b0;
        unique case (state_q)
            ST_SEARCH: begin
                if (step_i && !mis_i && run_q == RUN_W'(LOCK_RUN - 1)) begin
                    state_d    = ST_LOCKED;
                    lock_evt_o = 1'b1;
                end
            end
            ST_LOCKED: begin
                if (fail_i) begin
                    state_d = ST_SEARCH;
                end
            end
            default: state_d = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_SEARCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (state_q == ST_LOCKED) begin
            run_q <= '0;
        end else if (step_i) begin
            run_q <= (mis_i || lock_evt_o) ? '0 : run_q + 1'b1;
        end
    end

    assign locked_o = (state_q == ST_LOCKED);

    AST_LOCK_ON_GOOD_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(locked_o) |-> $past(step_i && !mis_i)); // R3

    AST_UNLOCK_ON_ERROR: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(locked_o) |-> $past(step_i && mis_i)); // R7

    AST_RUN_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q < RUN_W'(LOCK_RUN))); // R3

endmodule

// File: rtl/prbs9_win_mon.sv
module prbs9_win_mon #(
    parameter int unsigned PERIOD  = 128,
    parameter int unsigned MAX_ERR = 18
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    input  logic step_i,
    input  logic mis_i,
    output logic fail_o
);

    localparam int unsigned BIT_W = $clog2(PERIOD);
    localparam int unsigned ERR_W = $clog2(MAX_ERR + 1);

    logic [BIT_W-1:0] bits_q;
    logic [ERR_W-1:0] errs_q;
    logic             wrap;

    assign wrap   = step_i && (bits_q == BIT_W'(PERIOD - 1));
    assign fail_o = step_i && mis_i && (errs_q == ERR_W'(MAX_ERR));

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i || fail_o || wrap) begin
            bits_q <= '0;
            errs_q <= '0;
        end else if (step_i) begin
            bits_q <= bits_q + 1'b1;
            errs_q <= errs_q + ERR_W'(mis_i);
        end
    end

    AST_WIN_ERR_CAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (errs_q <= ERR_W'(MAX_ERR))); // R7

    AST_WIN_ERR_LE_BITS: assert property (@(posedge clk_i) disable iff (rst_i)
        (32'(errs_q) <= 32'(bits_q))); // R7

endmodule

// File: rtl/prbs9_sat_cnt.sv
module prbs9_sat_cnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_o == CNT_MAX && !clr_i) |=> (cnt_o == CNT_MAX)); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (cnt_o == '0)); // R9

endmodule

// File: rtl/prbs9_checker.sv
module prbs9_checker
    import prbs9_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned LOCK_RUN    = 18,
    parameter int unsigned WIN_LEN     = 128,
    parameter int unsigned WIN_MAX_ERR = 18
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             in_valid_i,
    input  logic             in_bit_i,
    output logic             locked_o,
    output logic             err_flag_o,
    output logic [CNT_W-1:0] bit_total_o,
    output logic [CNT_W-1:0] err_total_o
);

    localparam int unsigned N_TOTALS = 2;

    logic             pred;
    logic             mis;
    logic             locked;
    logic             lock_evt;
    logic             win_fail;
    logic             cnt_en;
    logic [N_TOTALS-1:0] cnt_inc;
    logic [CNT_W-1:0] totals [N_TOTALS];

    assign mis = in_bit_i ^ pred;

    prbs9_lfsr #(
        .LEN   (PRBS_LEN),
        .TAP_A (PRBS_TAP_A),
        .TAP_B (PRBS_TAP_B),
        .SEED  (PRBS_LEN'(1))
    ) u_lfsr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .step_i   (in_valid_i),
        .follow_i (!locked),
        .rx_bit_i (in_bit_i),
        .pred_o   (pred)
    );

    prbs9_sync_fsm #(
        .LOCK_RUN (LOCK_RUN)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .step_i     (in_valid_i),
        .mis_i      (mis),
        .fail_i     (win_fail),
        .locked_o   (locked),
        .lock_evt_o (lock_evt)
    );

    prbs9_win_mon #(
        .PERIOD  (WIN_LEN),
        .MAX_ERR (WIN_MAX_ERR)
    ) u_win (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (lock_evt),
        .step_i    (in_valid_i && locked),
        .mis_i     (mis),
        .fail_o    (win_fail)
    );

    assign cnt_en  = in_valid_i && locked;
    assign cnt_inc = {cnt_en && mis, cnt_en};

    for (genvar gi = 0; gi < N_TOTALS; gi++) begin : g_total
        prbs9_sat_cnt #(
            .W (CNT_W)
        ) u_cnt (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .clr_i (clr_i),
            .inc_i (cnt_inc[gi]),
            .cnt_o (totals[gi])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_flag_o <= 1'b0;
        end else begin
            err_flag_o <= in_valid_i && mis;
        end
    end

    assign locked_o    = locked;
    assign bit_total_o = totals[0];
    assign err_total_o = totals[1];

    AST_FLAG_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        err_flag_o |-> $past(in_valid_i)); // R2

    AST_NO_COUNT_IN_SEARCH: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!locked_o) && !$past(clr_i)) |-> $stable(bit_total_o)); // R5

    AST_ERRS_LE_BITS: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_total_o <= bit_total_o)); // R6

    AST_IDLE_NO_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (!in_valid_i) |=> !err_flag_o); // R10

endmodule

// File: tb/test_prbs9_checker.sv
module test_prbs9_checker;

    localparam int NSEG = 7;
    // columns: bits sent, flip period (0 none), lock at end, bit total,
    //          error total, flags seen, index where lock toggles (-1 none)
    localparam int SEG [0:NSEG-1][0:6] = '{
        '{ 18,  0, 1,   0,  0,  0, 17},
        '{100,  0, 1, 100,  0,  0, -1},
        '{ 28, 10, 1, 128,  2,  2, -1},
        '{128,  8, 1, 256, 18, 16, -1},
        '{128,  7, 1, 384, 36, 18, -1},
        '{ 40,  2, 0, 422, 55, 20, 37},
        '{ 30,  0, 1, 425, 55,  2, 26}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic locked, err_flag;
    logic [31:0] bit_total, err_total;
    logic locked_s, err_flag_s;
    logic [3:0] bit_total_s, err_total_s;

    logic [8:0] gen = 9'h001;
    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    prbs9_checker i_prbs9_checker (
        .clk_i(clk), .rst_i(rst), .clr_i(clr), .in_valid_i(in_valid),
        .in_bit_i(in_bit), .locked_o(locked), .err_flag_o(err_flag),
        .bit_total_o(bit_total), .err_total_o(err_total)
    );

    prbs9_checker #(.CNT_W(4)) i_prbs9_checker_sat (
        .clk_i(clk), .rst_i(rst), .clr_i(clr), .in_valid_i(in_valid),
        .in_bit_i(in_bit), .locked_o(locked_s), .err_flag_o(err_flag_s),
        .bit_total_o(bit_total_s), .err_total_o(err_total_s)
    );

    function automatic logic gen_next();
        logic r;
        r   = gen[8] ^ gen[4];
        gen = {gen[7:0], r};
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic flip, output logic flag);
        in_valid = 1'b1;
        in_bit   = gen_next() ^ flip;
        @(negedge clk);
        flag     = err_flag;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(locked == 1'b0, "R1 locked", locked, 0);
        check(err_flag == 1'b0, "R1 flag", err_flag, 0);
        check(bit_total == 0 && err_total == 0, "R1 totals", bit_total + err_total, 0);

        for (int e = 0; e < NSEG; e++) begin
            int chg, flags, bad;
            logic start_lock, fl;
            chg = -1; flags = 0; bad = 0;
            start_lock = locked;
            for (int i = 0; i < SEG[e][0]; i++) begin
                fl = (SEG[e][1] != 0) && (i % SEG[e][1] == SEG[e][1] - 1);
                send(fl, f);
                flags += int'(f);
                if (start_lock && chg < 0 && f !== fl) bad++;
                if (chg < 0 && locked !== start_lock) chg = i;
            end
            check(locked == SEG[e][2][0], "R3/R7 lock at end", locked, SEG[e][2]);
            check(bit_total == 32'(SEG[e][3]), "R5/R6 bit total", bit_total, SEG[e][3]);
            check(err_total == 32'(SEG[e][4]), "R5/R6 error total", err_total, SEG[e][4]);
            check(flags == SEG[e][5], "R2/R4 flag count", flags, SEG[e][5]);
            check(chg == SEG[e][6], "R3/R7 lock change index", chg, SEG[e][6]);
            check(bad == 0, "R6 flag follows corruption", bad, 0);
        end

        // R8 saturation on the narrow instance
        check(bit_total_s == 4'hF, "R8 bit total saturates", bit_total_s, 15);
        check(err_total_s == 4'hF, "R8 error total saturates", err_total_s, 15);

        // R10 idle cycles with a toggling data line
        begin
            int flags_idle;
            flags_idle = 0;
            for (int i = 0; i < 20; i++) begin
                in_bit = ~in_bit;
                @(negedge clk);
                flags_idle += int'(err_flag);
            end
            check(flags_idle == 0, "R10 no flag when idle", flags_idle, 0);
            check(bit_total == 425 && err_total == 55, "R10 totals hold", bit_total, 425);
            check(locked == 1'b1, "R10 lock holds", locked, 1);
            send(1'b0, f);
            check(f == 1'b0 && bit_total == 426, "R10 register undisturbed", bit_total, 426);
        end

        // R9 clear alone
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(bit_total == 0 && err_total == 0, "R9 clear totals", bit_total, 0);
        check(bit_total_s == 0, "R9 clear narrow totals", bit_total_s, 0);
        check(locked == 1'b1, "R9 clear keeps lock", locked, 1);

        // R9 clear wins over a counted errored bit
        clr = 1'b1;
        send(1'b1, f);
        clr = 1'b0;
        check(f == 1'b1, "R9 flag still shown", f, 1);
        check(bit_total == 0 && err_total == 0, "R9 clear priority", bit_total + err_total, 0);
        for (int i = 0; i < 5; i++) send(1'b0, f);
        check(bit_total == 5 && err_total == 0, "R9 counting resumes", bit_total, 5);

        // R1 mid-run reset, then R2/R4/R5 single corruption during search
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(locked == 1'b0 && err_flag == 1'b0, "R1 reset again", locked, 0);
        check(bit_total == 0, "R1 totals after reset", bit_total, 0);
        gen = 9'h001;
        begin
            logic [30:0] fmask;
            logic lock30;
            fmask = '0;
            lock30 = 1'b0;
            for (int i = 0; i < 31; i++) begin
                send(i == 3, f);
                fmask[i] = f;
                if (i == 29) lock30 = locked;
            end
            check(fmask == 31'((1 << 3) | (1 << 8) | (1 << 12)), "R4 three flag positions", fmask, (1 << 3) | (1 << 8) | (1 << 12));
            check(lock30 == 1'b0, "R3 no early lock", lock30, 0);
            check(locked == 1'b1, "R3 lock after run", locked, 1);
            check(bit_total == 0 && err_total == 0, "R5 search not counted", bit_total, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule